// File: doc/BRIEF.md
# UART Register Interface

This block is a bus-slave register front end for a serial port. It sits between a processor bus and two byte-wide valid/ready streams. One stream delivers received bytes from a deserializer, and the other hands bytes to be sent to a serializer. Software sees three 32-bit registers in a 24-byte window. The transmit data register is write-only. The receive data register is read-only. The status register holds two flags.

Received bytes land in a single-entry holding register. While that register is occupied, the block refuses further bytes by holding its receive ready output low. A read of the receive data register returns the held byte and frees the entry. A write to the transmit register places one byte in a single-entry output stage, and the byte leaves that stage on the outgoing stream. Reads return data one cycle after the access. Writes to the status register have no effect. Accesses that are not full words, and offsets that hold no register, do nothing.

Top module: `uart_regif`

## Requirements
- R1: After reset, every read returns 0 except a read of the status register, which returns 0x2. After reset, `tx_valid` is 0 and `rx_ready` is 1.
- R2: The register map uses byte offsets. Offset 0x00 is transmit data (reads as 0). Offset 0x04 is receive data. Offset 0x14 is status. In the status register, bit 0 is set while a received byte is held, bit 1 is set while the transmit stage is empty, and bits 31:2 read 0.
- R3: `rx_ready` is high exactly while no byte is held. A handshake (`rx_valid` with `rx_ready`) stores `rx_data` and sets status bit 0. While a byte is held, offered bytes are refused and the held byte does not change.
- R4: A read of offset 0x04 returns the held byte, zero-extended, on `bus_rdata` in the cycle after the access, and clears status bit 0. With no byte held, the same read returns the last byte stored and leaves the flag clear.
- R5: When a receive data read and an offered byte fall in the same cycle while a byte is held, the read returns the old byte. The new byte is accepted in the following cycle.
- R6: A write of any value to offset 0x14 leaves both status bits unchanged.
- R7: A write to offset 0x00 while the transmit stage is empty presents bits 7:0 of the write data on `tx_data` with `tx_valid` high from the next cycle. Both stay stable until `tx_ready` is seen high, after which `tx_valid` drops.
- R8: A write to offset 0x00 while `tx_valid` is high is dropped, and `tx_data` keeps the earlier byte.
- R9: A read of any offset other than 0x00, 0x04 and 0x14 returns 0. This includes offsets 0x18 to 0x1C, which lie outside the window. A write to such an offset changes no state.
- R10: An access with `bus_be` other than 4'hF, or with `bus_addr[1:0]` non-zero, is treated as unmapped. A read returns 0 and does not clear status bit 0. A write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address inside the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access, 0 otherwise |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Holding register can take a byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Consumer takes the outgoing byte |

## Verification
The hardest case to reach is a receive data read that lands in the same cycle as a new byte being offered while a byte is already held. That case decides whether the read sees the old byte and whether the new byte is lost or merely delayed. The bench first fills the holder. It then raises the bus read and `rx_valid` on the same falling edge. It watches `rx_ready` stay low through the read cycle and rise one cycle later. Finally it reads the new byte back. A second awkward case, a transmit write against a full output stage, is reached by holding `tx_ready` low across two writes.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned BUS_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WIN_BYTES = 24;

  localparam int unsigned TX_WORD = 0;
  localparam int unsigned RX_WORD = 1;
  localparam int unsigned ST_WORD = 5;

  localparam int unsigned ST_RX_BIT = 0;
  localparam int unsigned ST_TX_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TX   = 2'd1,
    SEL_RX   = 2'd2,
    SEL_ST   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/uart_regif_rstsync.sv
module uart_regif_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = (sync_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BE_W   = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output reg_sel_e          hit,
  output logic              acc_rd,
  output logic              acc_wr
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              full_acc;
  logic              in_win;
  logic [WORD_W-1:0] word;

  assign full_acc = (&be) && (addr[1:0] == 2'b00);
  assign in_win   = ({1'b0, addr} < (ADDR_W+1)'(WIN_BYTES));
  assign word     = addr[ADDR_W-1:2];

  always_comb begin
    hit = SEL_NONE;
    if (sel && full_acc && in_win) begin
      if (word == WORD_W'(TX_WORD)) begin
        hit = SEL_TX;
      end else if (word == WORD_W'(RX_WORD)) begin
        hit = SEL_RX;
      end else if (word == WORD_W'(ST_WORD)) begin
        hit = SEL_ST;
      end
    end
  end

  assign acc_rd = sel && !we;
  assign acc_wr = sel && we;

endmodule

// File: rtl/uart_regif_rxhold.sv
module uart_regif_rxhold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              clear,
  output logic              full,
  output logic [BYTE_W-1:0] hold
);

  logic              full_q, full_d, full_en;
  logic [BYTE_W-1:0] hold_q, hold_d, hold_en;
  logic              accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;

  always_comb begin
    full_d  = full_q;
    hold_d  = hold_q;
    full_en = 1'b0;
    hold_en = '0;
    if (accept) begin
      full_d  = 1'b1;
      hold_d  = in_data;
      full_en = 1'b1;
      hold_en = '1;
    end else if (clear) begin
      full_d  = 1'b0;
      full_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (full_en) begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (&hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign full = full_q;
  assign hold = hold_q;

  // R3: a handshake always leaves the holder occupied
  p_accept_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full);

  // R3: an occupied holder keeps its byte until cleared
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> (full && $stable(hold)));

  // R4: a data read frees an occupied holder
  p_clear_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && clear) |=> !full);

endmodule

// File: rtl/uart_regif_txstage.sv
module uart_regif_txstage #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              empty
);

  logic              valid_q, valid_d, valid_en;
  logic [BYTE_W-1:0] data_q;
  logic              load;

  assign load = wr && !valid_q;

  always_comb begin
    valid_d  = valid_q;
    valid_en = 1'b0;
    if (load) begin
      valid_d  = 1'b1;
      valid_en = 1'b1;
    end else if (valid_q && out_ready) begin
      valid_d  = 1'b0;
      valid_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load) begin
      data_q <= wdata;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign empty     = !valid_q;

  // R7: a write into an empty stage is presented next cycle
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && empty) |=> (out_valid && out_data == $past(wdata)));

  // R7: a pending byte holds until taken
  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a write against a full stage does not disturb the byte
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && out_valid) |=> $stable(out_data));

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);

  localparam int unsigned BE_W = BUS_W / 8;

  logic             rst_sync_n;
  reg_sel_e         hit;
  logic             acc_rd;
  logic             acc_wr;
  logic             rx_clear;
  logic             rx_full;
  logic [BYTE_W-1:0] rx_hold;
  logic             tx_wr;
  logic             tx_empty;
  logic [BUS_W-1:0] status_w;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             rdata_en;
  logic             unused_wdata_hi;

  uart_regif_rstsync #(
    .STAGES (SYNC_STAGES)
  ) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_regif_decode #(
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W)
  ) i_decode (
    .sel    (bus_sel),
    .we     (bus_we),
    .addr   (bus_addr),
    .be     (bus_be),
    .hit    (hit),
    .acc_rd (acc_rd),
    .acc_wr (acc_wr)
  );

  assign rx_clear = acc_rd && (hit == SEL_RX);
  assign tx_wr    = acc_wr && (hit == SEL_TX);

  uart_regif_rxhold #(
    .BYTE_W (BYTE_W)
  ) i_rxhold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_ready (rx_ready),
    .clear    (rx_clear),
    .full     (rx_full),
    .hold     (rx_hold)
  );

  uart_regif_txstage #(
    .BYTE_W (BYTE_W)
  ) i_txstage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (tx_wr),
    .wdata     (bus_wdata[BYTE_W-1:0]),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_ready (tx_ready),
    .empty     (tx_empty)
  );

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:BYTE_W];

  always_comb begin
    status_w            = '0;
    status_w[ST_RX_BIT] = rx_full;
    status_w[ST_TX_BIT] = tx_empty;
  end

  always_comb begin
    rdata_d = '0;
    if (acc_rd) begin
      case (hit)
        SEL_RX:  rdata_d = BUS_W'(rx_hold);
        SEL_ST:  rdata_d = status_w;
        default: rdata_d = '0;
      endcase
    end
  end

  assign rdata_en = acc_rd || (|rdata_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R6: a status write with no stream activity leaves the flags alone
  p_status_write_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_wr && hit == SEL_ST && !(rx_valid && rx_ready) && !(tx_valid && tx_ready))
    |=> $stable(status_w));

  // R9 and R10: unmapped or partial reads return zero
  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_rd && hit == SEL_NONE) |=> (bus_rdata == '0));

  // R10: an unmapped read never frees the holder
  p_bad_read_keeps_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_rd && hit == SEL_NONE && rx_full) |=> rx_full);

endmodule

// File: tb/test_uart_regif.sv
module test_uart_regif;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;

  int checks;
  int errors;
  bit done;

  localparam logic [4:0] A_TX = 5'h00;
  localparam logic [4:0] A_RX = 5'h04;
  localparam logic [4:0] A_ST = 5'h14;

  uart_regif i_uart_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [3:0] be, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] v);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    check("R3 ready before push", {31'd0, rx_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    check("R3 ready after push", {31'd0, rx_ready}, 32'd0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state at the ports
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    check("R1 rdata idle", bus_rdata, 32'd0);

    // R1 R2 R9: sweep every word offset after reset
    for (int w = 0; w < 8; w++) begin
      bus_rd(5'(w * 4), 4'hF, d);
      exp = (w == 5) ? 32'h2 : 32'h0;
      check("R1 R2 R9 word sweep", d, exp);
    end

    // R10: misaligned addresses read zero
    for (int a = 0; a < 32; a++) begin
      if ((a % 4) != 0) begin
        bus_rd(5'(a), 4'hF, d);
        check("R10 misaligned read", d, 32'h0);
      end
    end

    // R10: partial byte enables on status read zero
    for (int be = 0; be < 16; be++) begin
      bus_rd(A_ST, 4'(be), d);
      exp = (be == 15) ? 32'h2 : 32'h0;
      check("R10 byte enable sweep", d, exp);
    end

    // R3 R4 R2: every byte value through the holder
    for (int b = 0; b < 256; b++) begin
      rx_push(8'(b));
      bus_rd(A_ST, 4'hF, d);
      check("R2 status held", d, 32'h3);
      bus_rd(A_RX, 4'hF, d);
      check("R4 rx data", d, 32'(b));
      check("R4 ready after read", {31'd0, rx_ready}, 32'd1);
      bus_rd(A_ST, 4'hF, d);
      check("R4 status cleared", d, 32'h2);
    end

    // R4: read with nothing held returns last byte, flag stays clear
    bus_rd(A_RX, 4'hF, d);
    check("R4 empty reread", d, 32'hFF);
    bus_rd(A_ST, 4'hF, d);
    check("R4 empty reread status", d, 32'h2);

    // R3: refusal while held
    rx_push(8'hA5);
    rx_valid = 1'b1; rx_data = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      check("R3 refuse while held", {31'd0, rx_ready}, 32'd0);
    end
    rx_valid = 1'b0;

    // R10: partial and misaligned reads of rx do not clear the flag
    bus_rd(A_RX, 4'h7, d);
    check("R10 partial rx read", d, 32'h0);
    bus_rd(5'h05, 4'hF, d);
    check("R10 misaligned rx read", d, 32'h0);
    bus_rd(A_ST, 4'hF, d);
    check("R10 flag kept", d, 32'h3);

    // R6: status writes while held
    bus_wr(A_ST, 4'hF, 32'h0);
    bus_rd(A_ST, 4'hF, d);
    check("R6 status write 0 held", d, 32'h3);
    bus_wr(A_ST, 4'hF, 32'hFFFF_FFFF);
    bus_rd(A_ST, 4'hF, d);
    check("R6 status write ones held", d, 32'h3);

    // R5: read and offer in the same cycle
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_RX; bus_be = 4'hF;
    rx_valid = 1'b1; rx_data = 8'h5A;
    check("R5 ready low in read cycle", {31'd0, rx_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    check("R5 old byte returned", bus_rdata, 32'hA5);
    check("R5 ready next cycle", {31'd0, rx_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    check("R5 new byte taken", {31'd0, rx_ready}, 32'd0);
    bus_rd(A_RX, 4'hF, d);
    check("R5 new byte read", d, 32'h5A);

    // R6: status writes while empty
    bus_wr(A_ST, 4'hF, 32'h0000_0001);
    bus_rd(A_ST, 4'hF, d);
    check("R6 status write empty", d, 32'h2);
    check("R6 no tx", {31'd0, tx_valid}, 32'd0);

    // R9 R10: writes to unmapped, outside, partial, misaligned offsets
    for (int w = 2; w < 8; w++) begin
      if (w != 5) bus_wr(5'(w * 4), 4'hF, 32'hFFFF_FFFF);
    end
    bus_wr(A_TX, 4'h1, 32'h11);
    bus_wr(5'h01, 4'hF, 32'h22);
    bus_wr(5'h02, 4'hF, 32'h33);
    check("R9 R10 no tx after bad writes", {31'd0, tx_valid}, 32'd0);
    bus_rd(A_ST, 4'hF, d);
    check("R9 status after bad writes", d, 32'h2);
    bus_rd(A_RX, 4'hF, d);
    check("R9 rx after bad writes", d, 32'h5A);

    // R7: every byte value through the transmit stage
    for (int b = 0; b < 256; b++) begin
      bus_wr(A_TX, 4'hF, {24'hC0FFEE ^ 24'(b), 8'(b)});
      check("R7 tx_valid", {31'd0, tx_valid}, 32'd1);
      check("R7 tx_data", {24'd0, tx_data}, 32'(b));
      bus_rd(A_ST, 4'hF, d);
      check("R2 status tx busy", d, 32'h0);
      check("R7 held until ready", {24'd0, tx_data}, 32'(b));
      tx_ready = 1'b1;
      tick(1);
      tx_ready = 1'b0;
      check("R7 drained", {31'd0, tx_valid}, 32'd0);
    end

    // R2: transmit register reads as zero
    bus_rd(A_TX, 4'hF, d);
    check("R2 tx reads zero", d, 32'h0);

    // R8: second write while full is dropped
    bus_wr(A_TX, 4'hF, 32'h0000_0077);
    bus_wr(A_TX, 4'hF, 32'h0000_0088);
    check("R8 first byte kept", {24'd0, tx_data}, 32'h77);
    check("R8 still valid", {31'd0, tx_valid}, 32'd1);
    tx_ready = 1'b1;
    tick(1);
    tx_ready = 1'b0;
    check("R8 nothing queued", {31'd0, tx_valid}, 32'd0);
    bus_rd(A_ST, 4'hF, d);
    check("R8 status empty", d, 32'h2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule